// File: doc/BRIEF.md
# Serial NOR flash command front end

This block is the device side of a serial NOR flash interface. It watches the serial clock, the active-low select and the serial data input, assembles eight-bit bus cycles, decodes the opcode, and turns each complete command into a request on a simple request/acknowledge port toward the memory array. It holds the write-enable latch, the busy flag and a small status register. It returns array data, status and identification bytes on the serial output.

The serial pins are sampled by the block's own clock, which must run at least eight times faster than the serial clock. A write-type command takes effect only when the select rises on a byte boundary after all of its required bytes, and only with the write-enable latch set. Word programming with automatic address increment keeps its address inside the block, so each later word needs only the opcode and two data bytes.

Top module: `spi_flash_cmd_slave`

## Requirements
- R1: Bytes are shifted in on rising serial clock edges while select is low, most significant bit first, eight bits per byte; the first byte after select falls is the opcode and the next three bytes form a 24-bit address, high byte first.
- R2: Opcode 06h sets the write-enable latch (status bit 1). Opcode 04h clears the latch and ends word-program mode (status bit 6).
- R3: Program, word program, erase and chip erase are dropped unless the latch is set. Status write also proceeds after opcode 50h. Request codes on req_op are: 0 read, 1 program byte, 2 erase 4 KB, 3 erase 32 KB, 4 erase 64 KB, 5 erase chip, 6 status write.
- R4: If select rises with a byte partly shifted, or before all required bytes, the command is abandoned. No request is issued and no latch changes.
- R5: Opcode 03h reads from the address with no dummy byte. Data bytes leave on the serial output MSB first, changing on falling clock edges. The address advances by one for each byte.
- R6: Opcode 0Bh inserts one dummy byte after the address and then streams like 03h.
- R7: Opcodes 20h, 52h and D8h erase 4 KB, 32 KB and 64 KB. The requested address keeps bits 12, 15 and 16 upward and clears the bits below.
- R8: Opcodes 60h and C7h both request a chip erase with address 0.
- R9: Opcode 02h programs the first data byte after the address at that address.
- R10: The first ADh carries an address and two data bytes. It programs byte 0 at the even address and byte 1 at the odd address. Each later ADh carries two data bytes for the next word. Status bit 6 is set during this mode.
- R11: Opcode 05h streams the status byte {bit7 stored, bit6 word mode, bits 5:2 stored, bit1 latch, bit0 busy} for as long as clocks arrive. Opcode 01h stores its first data byte into the stored bits and its second byte into a second register read back by 35h.
- R12: Opcodes 90h/ABh stream identification bytes after a 3-byte address. Address bit 0 clear starts with the maker code 5Ah, set starts with the device code 3Ch, and the two alternate. Opcode 9Fh streams 5Ah, 25h, 8Ch repeating.
- R13: Busy is set from a write request until its last acknowledge. Write-type commands arriving while busy are dropped, and status still reads. The latch clears when a program, erase or status write completes, outside word-program mode.
- R14: The serial output is enabled only while select is low. After 70h, in word-program mode with no data streaming, it shows ready (1) or busy (0). 80h turns this off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, sampling the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |
| req_valid | output | 1 | Request to the array, held until acknowledged |
| req_op | output | 3 | Request code |
| req_addr | output | 24 | Request byte address |
| req_data | output | 8 | Program or status data |
| req_ack | input | 1 | One-cycle acknowledge from the array |
| rd_data | input | 8 | Read data, valid with req_ack on a read |

## Verification
On every cycle, the assertions check the following. No write request starts without the write-enable latch (or the status-write enable). A pending request holds its fields until acknowledged. Busy covers every outstanding write. Erase addresses are aligned to their region. Select rising mid-byte never launches a request, and the odd-address word byte follows its even partner directly. The bench scenarios are needed for byte order and content. These include read and fast-read streams with address increment, identification sequencing by address bit 0, status contents, the dropping of commands while busy or with too few bytes, and the ready/busy level on the output during word programming.

// File: rtl/spi_flash_cmd_slave.sv
module spi_flash_cmd_slave #(
  parameter int ADDR_BYTES = 3,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'h3C,
  parameter logic [7:0] JED_TYPE = 8'h25,
  parameter logic [7:0] JED_CAP = 8'h8C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sck,
  input  logic                    cs_n,
  input  logic                    si,
  output logic                    so,
  output logic                    so_oe,
  output logic                    req_valid,
  output logic [2:0]              req_op,
  output logic [8*ADDR_BYTES-1:0] req_addr,
  output logic [7:0]              req_data,
  input  logic                    req_ack,
  input  logic [7:0]              rd_data
);
  localparam int AW = 8 * ADDR_BYTES;
  localparam logic [3:0] NB_A = 4'(ADDR_BYTES);
  localparam logic [3:0] NB_D = NB_A + 4'd1;
  localparam logic [AW-1:0] LO4K  = AW'(32'h0FFF);
  localparam logic [AW-1:0] LO32K = AW'(32'h7FFF);
  localparam logic [AW-1:0] LO64K = AW'(32'hFFFF);

  localparam logic [7:0] OP_READ = 8'h03, OP_FREAD = 8'h0B, OP_E4K = 8'h20, OP_E32K = 8'h52,
                         OP_E64K = 8'hD8, OP_CE_A = 8'h60, OP_CE_B = 8'hC7, OP_PROG = 8'h02,
                         OP_AAI = 8'hAD, OP_RDSR = 8'h05, OP_RDCF = 8'h35, OP_EWSR = 8'h50,
                         OP_WRSR = 8'h01, OP_WREN = 8'h06, OP_WRDI = 8'h04, OP_ID_A = 8'h90,
                         OP_ID_B = 8'hAB, OP_JEDEC = 8'h9F, OP_BYON = 8'h70, OP_BYOFF = 8'h80;

  localparam logic [2:0] RQ_READ = 3'd0, RQ_PROG = 3'd1, RQ_E4K = 3'd2, RQ_E32K = 3'd3,
                         RQ_E64K = 3'd4, RQ_CHIP = 3'd5, RQ_WRSR = 3'd6;

  logic          sck_q, cs_q;
  logic [2:0]    bit_cnt;
  logic [3:0]    nbytes;
  logic [6:0]    sin;
  logic [7:0]    opc, d0, d1, pdata, sr, cfg, shreg, rbuf;
  logic [AW-1:0] addr, raddr, aai_next;
  logic          wel, ewsr, aai, by_en, busy, pend2, out_act;
  logic [1:0]    seq;

  wire       sck_rise  = sck & ~sck_q & ~cs_n;
  wire       sck_fall  = ~sck & sck_q & ~cs_n;
  wire       cs_rise   = cs_n & ~cs_q;
  wire [7:0] byte_in   = {sin, si};
  wire       byte_done = sck_rise && bit_cnt == 3'd7;
  wire       aai_cont  = aai && opc == OP_AAI;
  wire       short_dat = aai_cont || opc == OP_WRSR;
  wire [3:0] dstart    = short_dat ? 4'd1 : NB_D;
  wire       in_addr   = nbytes != 4'd0 && nbytes <= NB_A && !short_dat;
  wire       is_read   = opc == OP_READ || opc == OP_FREAD;
  wire [7:0] stat      = {sr[7], aai, sr[5:2], wel, busy};
  wire       on_bound  = cs_rise && bit_cnt == 3'd0 && nbytes != 4'd0;
  wire       wr_win    = on_bound && !busy && !req_valid;
  wire       ry_show   = aai && by_en && !out_act;

  assign so    = ry_show ? ~busy : shreg[7];
  assign so_oe = ~cs_n & (out_act | (aai & by_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; cs_q <= 1'b1; bit_cnt <= '0; nbytes <= '0; sin <= '0;
      opc <= '0; addr <= '0; d0 <= '0; d1 <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
        nbytes  <= '0;
      end else if (sck_rise) begin
        sin     <= {sin[5:0], si};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          if (nbytes != 4'hF) nbytes <= nbytes + 4'd1;
          if (nbytes == 4'd0) opc <= byte_in;
          else if (in_addr) addr <= {addr[AW-9:0], byte_in};
          if (nbytes != 4'd0 && nbytes == dstart) d0 <= byte_in;
          if (nbytes != 4'd0 && nbytes == dstart + 4'd1) d1 <= byte_in;
        end
      end
    end
  end

  logic       load_ok, rd_next, idsel;
  logic [7:0] load_val;
  logic [1:0] seq_nxt, jsel;

  always_comb begin
    load_ok = 1'b0; rd_next = 1'b0; load_val = 8'hFF; seq_nxt = seq;
    idsel = (nbytes == NB_D) ? addr[0] : seq[0];
    jsel  = (nbytes == 4'd1) ? 2'd0 : seq;
    unique case (opc)
      OP_READ:  begin load_ok = nbytes >= NB_D;         load_val = rbuf; rd_next = 1'b1; end
      OP_FREAD: begin load_ok = nbytes >= NB_D + 4'd1;  load_val = rbuf; rd_next = 1'b1; end
      OP_RDSR:  begin load_ok = 1'b1; load_val = stat; end
      OP_RDCF:  begin load_ok = 1'b1; load_val = cfg; end
      OP_ID_A, OP_ID_B: begin
        load_ok  = nbytes >= NB_D;
        load_val = idsel ? DEV_ID : MFR_ID;
        seq_nxt  = {1'b0, ~idsel};
      end
      OP_JEDEC: begin
        load_ok = 1'b1;
        case (jsel)
          2'd1:    load_val = JED_TYPE;
          2'd2:    load_val = JED_CAP;
          default: load_val = MFR_ID;
        endcase
        seq_nxt = (jsel == 2'd2) ? 2'd0 : jsel + 2'd1;
      end
      default: load_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= 8'hFF; out_act <= 1'b0; seq <= '0;
    end else if (cs_n) begin
      out_act <= 1'b0;
    end else if (sck_fall) begin
      if (bit_cnt == 3'd0 && nbytes != 4'd0 && load_ok) begin
        shreg   <= load_val;
        out_act <= 1'b1;
        seq     <= seq_nxt;
      end else begin
        shreg <= {shreg[6:0], 1'b1};
      end
    end
  end

  logic          wr_go;
  logic [2:0]    wr_op;
  logic [AW-1:0] wr_addr;

  always_comb begin
    wr_go = 1'b0; wr_op = RQ_PROG; wr_addr = addr;
    unique case (opc)
      OP_PROG: wr_go = wr_win && wel && nbytes >= NB_D + 4'd1;
      OP_AAI: begin
        if (aai) begin
          wr_go = wr_win && wel && nbytes >= 4'd3;
          wr_addr = aai_next;
        end else begin
          wr_go = wr_win && wel && nbytes >= NB_D + 4'd2;
          wr_addr = {addr[AW-1:1], 1'b0};
        end
      end
      OP_E4K:  begin wr_go = wr_win && wel && nbytes >= NB_D; wr_op = RQ_E4K;  wr_addr = addr & ~LO4K;  end
      OP_E32K: begin wr_go = wr_win && wel && nbytes >= NB_D; wr_op = RQ_E32K; wr_addr = addr & ~LO32K; end
      OP_E64K: begin wr_go = wr_win && wel && nbytes >= NB_D; wr_op = RQ_E64K; wr_addr = addr & ~LO64K; end
      OP_CE_A, OP_CE_B: begin wr_go = wr_win && wel; wr_op = RQ_CHIP; wr_addr = '0; end
      OP_WRSR: begin wr_go = wr_win && (wel || ewsr) && nbytes >= 4'd2; wr_op = RQ_WRSR; wr_addr = '0; end
      default: wr_go = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0; ewsr <= 1'b0; aai <= 1'b0; by_en <= 1'b0; busy <= 1'b0; pend2 <= 1'b0;
      pdata <= '0; sr <= '0; cfg <= '0; raddr <= '0; rbuf <= '0; aai_next <= '0;
      req_valid <= 1'b0; req_op <= RQ_READ; req_addr <= '0; req_data <= '0;
    end else begin
      if (req_valid && req_ack) begin
        if (req_op == RQ_READ) begin
          rbuf      <= rd_data;
          req_valid <= 1'b0;
        end else if (pend2) begin
          req_addr <= {req_addr[AW-1:1], 1'b1};
          req_data <= pdata;
          pend2    <= 1'b0;
        end else begin
          req_valid <= 1'b0;
          busy      <= 1'b0;
          if (!aai) wel <= 1'b0;
        end
      end

      if (byte_done && nbytes == NB_A && is_read && !req_valid) begin
        req_valid <= 1'b1;
        req_op    <= RQ_READ;
        req_addr  <= {addr[AW-9:0], byte_in};
        raddr     <= {addr[AW-9:0], byte_in};
      end else if (sck_fall && bit_cnt == 3'd0 && nbytes != 4'd0 && load_ok && rd_next && !req_valid) begin
        req_valid <= 1'b1;
        req_op    <= RQ_READ;
        req_addr  <= raddr + AW'(1);
        raddr     <= raddr + AW'(1);
      end

      if (on_bound) begin
        case (opc)
          OP_WREN:  wel <= 1'b1;
          OP_WRDI:  begin wel <= 1'b0; aai <= 1'b0; end
          OP_EWSR:  ewsr <= 1'b1;
          OP_BYON:  by_en <= 1'b1;
          OP_BYOFF: by_en <= 1'b0;
          default: ;
        endcase
      end

      if (wr_go) begin
        req_valid <= 1'b1;
        req_op    <= wr_op;
        req_addr  <= wr_addr;
        req_data  <= d0;
        busy      <= 1'b1;
        if (opc == OP_AAI) begin
          aai      <= 1'b1;
          pend2    <= 1'b1;
          pdata    <= d1;
          aai_next <= wr_addr + AW'(2);
        end
        if (opc == OP_WRSR) begin
          sr   <= d0 & 8'hBC;
          ewsr <= 1'b0;
          if (nbytes >= 4'd3) cfg <= d1;
        end
      end
    end
  end

  p_wel_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && req_op != RQ_READ |-> $past(wel || ewsr));

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_op) && $stable(req_data));

  p_busy_cover_r13: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_op != RQ_READ |-> busy);

  p_erase_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !((req_op == RQ_E4K && req_addr[11:0] != 12'd0) ||
                    (req_op == RQ_E32K && req_addr[14:0] != 15'd0) ||
                    (req_op == RQ_E64K && req_addr[15:0] != 16'd0)));

  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && bit_cnt != 3'd0 |=> !$rose(req_valid));

  p_aai_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ack && pend2 |=> req_valid && req_addr[0] && req_op == RQ_PROG);

  p_oe_idle_r14: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && cs_q |-> !so_oe && !out_act);
endmodule

// File: tb/spi_flash_cmd_slave_test.sv
module spi_flash_cmd_slave_test;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, req_valid, req_ack;
  logic [2:0]  req_op;
  logic [23:0] req_addr;
  logic [7:0]  req_data, rd_data;
  logic hold = 1'b0;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  spi_flash_cmd_slave uut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .so(so), .so_oe(so_oe),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .req_ack(req_ack), .rd_data(rd_data));

  function automatic logic [7:0] memv(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  logic [2:0]  lg_op   [32];
  logic [23:0] lg_addr [32];
  logic [7:0]  lg_data [32];
  int lg_n = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      req_ack <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      req_ack <= 1'b0;
      if (req_valid && !req_ack && !hold) begin
        req_ack <= 1'b1;
        if (req_op == 3'd0) rd_data <= memv(req_addr);
        else begin
          lg_op[lg_n[4:0]]   <= req_op;
          lg_addr[lg_n[4:0]] <= req_addr;
          lg_data[lg_n[4:0]] <= req_data;
          lg_n <= lg_n + 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0; tick(8);
  endtask

  task automatic desel();
    tick(4); cs_n = 1'b1; tick(12);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i > 7 - n; i--) begin
      si = tx[i]; rx[i] = so;
      tick(4); sck = 1'b1; tick(8); sck = 1'b0; tick(4);
    end
  endtask

  task automatic xb(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  logic [7:0] r, v0, v1, v2, v3;

  task automatic cmd1(input logic [7:0] op);
    sel(); xb(op, r); desel();
  endtask

  task automatic rdreg(input logic [7:0] op, output logic [7:0] v);
    sel(); xb(op, r); xb(8'h00, v); desel();
  endtask

  task automatic send_addr(input logic [23:0] a);
    xb(a[23:16], r); xb(a[15:8], r); xb(a[7:0], r);
  endtask

  localparam logic [70:0] VEC [6] = '{
    {8'h20, 4'd3, 24'h123456, 8'h00, 3'd2, 24'h123000},
    {8'h52, 4'd3, 24'h123456, 8'h00, 3'd3, 24'h120000},
    {8'hD8, 4'd3, 24'h12F456, 8'h00, 3'd4, 24'h120000},
    {8'h60, 4'd0, 24'h000000, 8'h00, 3'd5, 24'h000000},
    {8'hC7, 4'd0, 24'h000000, 8'h00, 3'd5, 24'h000000},
    {8'h02, 4'd4, 24'h00ABCD, 8'h5C, 3'd1, 24'h00ABCD}
  };
  logic [7:0] vop, vdt;
  logic [3:0] vnb;
  logic [23:0] vad, vea;
  logic [2:0] veo;
  int n0;

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R14 reset so_oe", so_oe, 0);
    chk("R13 reset req_valid", req_valid, 0);

    // R11: status streams while clocked
    sel(); xb(8'h05, r); xb(8'h00, v0); xb(8'h00, v1); desel();
    chk("R11 status first", v0, 8'h00);
    chk("R11 status repeat", v1, 8'h00);

    cmd1(8'h06); rdreg(8'h05, v0); chk("R2 latch set", v0, 8'h02);
    cmd1(8'h04); rdreg(8'h05, v0); chk("R2 latch clear", v0, 8'h00);

    // R3: no latch, no request
    n0 = lg_n;
    sel(); xb(8'h20, r); send_addr(24'h123456); desel();
    cmd1(8'h60);
    chk("R3 gated writes", lg_n - n0, 0);

    // R4: abort cases
    sel(); xbits(8'h06, 5, r); desel();
    rdreg(8'h05, v0); chk("R4 partial enable", v0, 8'h00);
    cmd1(8'h06);
    n0 = lg_n;
    sel(); xb(8'h20, r); xb(8'h12, r); xb(8'h34, r); desel();
    sel(); xb(8'h60, r); xbits(8'h00, 3, r); desel();
    chk("R4 short or split", lg_n - n0, 0);
    rdreg(8'h05, v0); chk("R4 latch kept", v0, 8'h02);
    cmd1(8'h04);

    // R1 and R5: plain read
    sel(); xb(8'h03, r); send_addr(24'h000010);
    xb(8'h00, v0); xb(8'h00, v1); xb(8'h00, v2); desel();
    chk("R1/R5 read byte0", v0, memv(24'h000010));
    chk("R5 read byte1", v1, memv(24'h000011));
    chk("R5 read byte2", v2, memv(24'h000012));

    // R6: fast read with dummy
    sel(); xb(8'h0B, r); send_addr(24'h0102FE); xb(8'h00, r);
    xb(8'h00, v0); xb(8'h00, v1); xb(8'h00, v2); desel();
    chk("R6 fast byte0", v0, memv(24'h0102FE));
    chk("R6 fast byte1", v1, memv(24'h0102FF));
    chk("R6 fast carry", v2, memv(24'h010300));

    // R7, R8, R9 table with latch auto clear (R13)
    for (int k = 0; k < 6; k++) begin
      {vop, vnb, vad, vdt, veo, vea} = VEC[k];
      cmd1(8'h06);
      n0 = lg_n;
      sel(); xb(vop, r);
      for (int j = 0; j < int'(vnb); j++) begin
        if (j < 3) xb(vad[23-8*j -: 8], r);
        else xb(vdt, r);
      end
      desel();
      chk("R7/R8/R9 request count", lg_n - n0, 1);
      chk("R7/R8/R9 request code", lg_op[n0[4:0]], veo);
      chk("R7/R8/R9 request address", lg_addr[n0[4:0]], vea);
      if (veo == 3'd1) chk("R9 program data", lg_data[n0[4:0]], vdt);
      rdreg(8'h05, v0); chk("R13 latch auto clear", v0, 8'h00);
    end

    // R10: word programming
    cmd1(8'h06);
    n0 = lg_n;
    sel(); xb(8'hAD, r); send_addr(24'h001001); xb(8'h11, r); xb(8'h22, r); desel();
    chk("R10 first pair count", lg_n - n0, 2);
    chk("R10 even address", lg_addr[n0[4:0]], 24'h001000);
    chk("R10 even data", lg_data[n0[4:0]], 8'h11);
    chk("R10 odd address", lg_addr[(n0 + 1) & 31], 24'h001001);
    chk("R10 odd data", lg_data[(n0 + 1) & 31], 8'h22);
    rdreg(8'h05, v0); chk("R10 mode status", v0, 8'h42);
    sel(); xb(8'hAD, r); xb(8'h33, r); xb(8'h44, r); desel();
    chk("R10 next even address", lg_addr[(n0 + 2) & 31], 24'h001002);
    chk("R10 next odd data", lg_data[(n0 + 3) & 31], 8'h44);
    cmd1(8'h04); rdreg(8'h05, v0); chk("R2 disable ends word mode", v0, 8'h00);

    // R13: busy holds off new writes
    hold = 1'b1;
    cmd1(8'h06);
    n0 = lg_n;
    sel(); xb(8'h60, r); desel();
    chk("R13 request pending", req_valid, 1);
    rdreg(8'h05, v0); chk("R13 busy status", v0, 8'h03);
    cmd1(8'h06);
    sel(); xb(8'h20, r); send_addr(24'h000000); desel();
    hold = 1'b0;
    tick(10);
    chk("R13 busy drop count", lg_n - n0, 1);
    chk("R13 completed code", lg_op[n0[4:0]], 3'd5);
    rdreg(8'h05, v0); chk("R13 idle status", v0, 8'h00);

    // R12: identification
    sel(); xb(8'h90, r); send_addr(24'h000000); xb(0, v0); xb(0, v1); xb(0, v2); desel();
    chk("R12 id maker", v0, 8'h5A);
    chk("R12 id device", v1, 8'h3C);
    chk("R12 id alternate", v2, 8'h5A);
    sel(); xb(8'hAB, r); send_addr(24'h000001); xb(0, v0); xb(0, v1); desel();
    chk("R12 odd start device", v0, 8'h3C);
    chk("R12 odd then maker", v1, 8'h5A);
    sel(); xb(8'h9F, r); xb(0, v0); xb(0, v1); xb(0, v2); xb(0, v3); desel();
    chk("R12 jedec maker", v0, 8'h5A);
    chk("R12 jedec type", v1, 8'h25);
    chk("R12 jedec capacity", v2, 8'h8C);
    chk("R12 jedec wrap", v3, 8'h5A);

    // R11: status write
    sel(); xb(8'h01, r); xb(8'hFC, r); desel();
    rdreg(8'h05, v0); chk("R11 ungated write dropped", v0, 8'h00);
    cmd1(8'h50);
    n0 = lg_n;
    sel(); xb(8'h01, r); xb(8'h3C, r); xb(8'h5A, r); desel();
    chk("R11 write request code", lg_op[n0[4:0]], 3'd6);
    chk("R11 write request data", lg_data[n0[4:0]], 8'h3C);
    rdreg(8'h05, v0); chk("R11 stored bits", v0, 8'h3C);
    rdreg(8'h35, v0); chk("R11 second register", v0, 8'h5A);
    sel(); xb(8'h01, r); xb(8'h00, r); desel();
    rdreg(8'h05, v0); chk("R11 enable used once", v0, 8'h3C);

    // R14: ready/busy on output during word programming
    cmd1(8'h70);
    cmd1(8'h06);
    hold = 1'b1;
    sel(); xb(8'hAD, r); send_addr(24'h002000); xb(8'h55, r); xb(8'h66, r); desel();
    sel(); tick(4);
    chk("R14 indicator enabled", so_oe, 1);
    chk("R14 shows busy", so, 0);
    hold = 1'b0;
    tick(10);
    chk("R14 shows ready", so, 1);
    desel();
    chk("R14 released when deselected", so_oe, 0);
    cmd1(8'h04);
    cmd1(8'h80);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule